// File: doc/BRIEF.md
# Producer-Consumer Named Barrier Unit

The block coordinates thread slots through a bank of independent named barriers. A producer posts a non-blocking *arrive* on a barrier, carrying a participant count; a consumer posts a blocking *sync* on a barrier, carrying the number of arrivals it needs before it may continue. Arrivals and waits are asymmetric: a sync never counts as an arrival. Each barrier keeps an arrival counter and a signed participant counter. The participant counter is raised to the largest count any arrive has carried, and it drops by one each time a sync completes. When it drains to zero, the arrival count is cleared and the barrier starts over.

Commands enter one per cycle on a valid/ready port with four fields: the operation, a barrier number, a thread slot number and a count. A sync that is already satisfied completes at once. Otherwise its slot is parked in a wait table together with its barrier and its required count. After every arrive, the unit walks the whole wait table, one slot per cycle, and frees every slot parked on that barrier whose requirement is now met. Each freed or immediately completed slot is announced as a one-cycle pulse with its slot number on the release port. A sync from a slot that is still parked is a protocol error: it is reported on the error port and otherwise ignored.

Top module: `nb_barrier_unit`

## Requirements
- R1: After reset, cmd_ready is 1, rel_valid and err_valid are 0, and every barrier has zero arrivals and a participant count of zero. A sync with a required count of 1 on any barrier therefore does not complete.
- R2: An accepted arrive (cmd_op = 0) adds one to the selected barrier's arrival count. It sets that barrier's participant count to the larger of the current value and cmd_cnt, compared as signed numbers.
- R3: An accepted sync (cmd_op = 1) from a slot that is not parked completes at once if the barrier's arrival count is at least cmd_cnt. In the cycle after acceptance, rel_valid is 1 for one cycle with rel_tid equal to cmd_tid.
- R4: A sync never changes any arrival count. An unsatisfied sync parks its slot, recording the barrier and the required count, and produces no release.
- R5: After an arrive is accepted, slots 0 to NUM_THREADS-1 are examined in ascending order, one per cycle. Slot k is examined in the k-th cycle after acceptance, and its release pulse is visible one cycle later. A slot is released if it is parked on that barrier and its required count is no greater than the barrier's current arrival count. All other slots stay parked.
- R6: Every completed sync, whether immediate or released by the walk, lowers the barrier's participant count by one. When the count goes from 1 to 0, the arrival count is cleared, so later syncs must wait for new arrivals.
- R7: The participant count is signed and may fall below zero, for example when a sync with a required count of 0 completes before any arrive. Falling from 0 to -1 does not clear the arrival count.
- R8: cmd_ready is 0 for exactly NUM_THREADS cycles after an arrive is accepted, and it is 1 at all other times after reset. At most one command is taken per cycle.
- R9: A sync from a slot that is still parked is dropped. In the next cycle, err_valid is 1 for one cycle with err_tid equal to that slot, and rel_valid is 0. The parked entry and all counters are left unchanged. rel_valid and err_valid are never 1 together.
- R10: Barriers are independent. An arrive on one barrier never releases a slot parked on another barrier.
- R11: The arrival count saturates at 2^CNT_W-1. The participant count saturates at -(2^CNT_W) when lowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken this cycle when high together with cmd_valid |
| cmd_op | input | 1 | 0 = arrive, 1 = sync |
| cmd_bar | input | $clog2(NUM_BARRIERS) | Barrier number |
| cmd_tid | input | $clog2(NUM_THREADS) | Issuing thread slot |
| cmd_cnt | input | CNT_W | Participant count (arrive) or required arrivals (sync) |
| rel_valid | output | 1 | One-cycle pulse: a sync has completed |
| rel_tid | output | $clog2(NUM_THREADS) | Slot whose sync completed |
| err_valid | output | 1 | One-cycle pulse: a sync came from a parked slot |
| err_tid | output | $clog2(NUM_THREADS) | Slot that caused the error |

## Verification
The bench builds the unit with 4 barriers, 8 thread slots and 4-bit counts. Each wait-table walk then takes eight cycles, so every slot of every walk can be compared cycle by cycle with a model in the bench. The 4-bit counts bring both saturation limits within a few dozen commands. With only four barriers and eight slots, random traffic often re-syncs slots that are already parked, drives participant counts negative, and clears barriers in the middle of a walk.

// File: rtl/nb_pkg.sv
package nb_pkg;
  typedef enum logic {
    OP_ARRIVE = 1'b0,
    OP_SYNC   = 1'b1
  } nb_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } nb_state_e;
endpackage

// File: rtl/nb_rst_sync.sv
module nb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/nb_counter_bank.sv
module nb_counter_bank #(
  parameter int NUM_BARRIERS = 16,
  parameter int CNT_W        = 11,
  localparam int BAR_W       = $clog2(NUM_BARRIERS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              arr_en,
  input  logic [BAR_W-1:0]                  arr_bar,
  input  logic [CNT_W-1:0]                  arr_cnt_in,
  input  logic                              done_en,
  input  logic [BAR_W-1:0]                  done_bar,
  output logic [NUM_BARRIERS-1:0][CNT_W-1:0] arr_cnt,
  output logic [NUM_BARRIERS-1:0][CNT_W:0]   part_cnt
);
  localparam logic [CNT_W-1:0] ARR_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   PART_MIN = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0]   PART_ONE = {{CNT_W{1'b0}}, 1'b1};

  for (genvar b = 0; b < NUM_BARRIERS; b++) begin : g_bar
    logic             sel_arr, sel_done, upd_en;
    logic [CNT_W-1:0] arr_q, arr_nxt;
    logic [CNT_W:0]   part_q, part_nxt;

    always_comb begin
      sel_arr  = arr_en  && (arr_bar  == BAR_W'(b));
      sel_done = done_en && (done_bar == BAR_W'(b));
      upd_en   = sel_arr || sel_done;
      arr_nxt  = arr_q;
      part_nxt = part_q;
      if (sel_arr) begin
        if (arr_q != ARR_MAX) arr_nxt = arr_q + 1'b1;
        if ($signed({1'b0, arr_cnt_in}) > $signed(part_q)) part_nxt = {1'b0, arr_cnt_in};
      end else if (sel_done) begin
        if (part_q == PART_ONE) arr_nxt = '0;
        if (part_q != PART_MIN) part_nxt = part_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arr_q  <= '0;
        part_q <= '0;
      end else if (upd_en) begin
        arr_q  <= arr_nxt;
        part_q <= part_nxt;
      end
    end

    assign arr_cnt[b]  = arr_q;
    assign part_cnt[b] = part_q;
  end
endmodule

// File: rtl/nb_wait_table.sv
module nb_wait_table #(
  parameter int NUM_THREADS  = 1024,
  parameter int NUM_BARRIERS = 16,
  parameter int CNT_W        = 11,
  localparam int TID_W       = $clog2(NUM_THREADS),
  localparam int BAR_W       = $clog2(NUM_BARRIERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TID_W-1:0] set_tid,
  input  logic [BAR_W-1:0] set_bar,
  input  logic [CNT_W-1:0] set_req,
  input  logic             clr_en,
  input  logic [TID_W-1:0] clr_tid,
  input  logic [TID_W-1:0] qa_tid,
  output logic             qa_blocked,
  input  logic [TID_W-1:0] qb_tid,
  output logic             qb_blocked,
  output logic [BAR_W-1:0] qb_bar,
  output logic [CNT_W-1:0] qb_req
);
  logic [NUM_THREADS-1:0] blk_q, blk_nxt;
  logic                   blk_en;
  logic [BAR_W-1:0]       bar_q [NUM_THREADS];
  logic [CNT_W-1:0]       req_q [NUM_THREADS];

  always_comb begin
    blk_nxt = blk_q;
    blk_en  = set_en || clr_en;
    if (set_en) blk_nxt[set_tid] = 1'b1;
    if (clr_en) blk_nxt[clr_tid] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (blk_en) begin
      blk_q <= blk_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) begin
      bar_q[set_tid] <= set_bar;
      req_q[set_tid] <= set_req;
    end
  end

  assign qa_blocked = blk_q[qa_tid];
  assign qb_blocked = blk_q[qb_tid];
  assign qb_bar     = bar_q[qb_tid];
  assign qb_req     = req_q[qb_tid];
endmodule

// File: rtl/nb_ctrl.sv
module nb_ctrl
  import nb_pkg::*;
#(
  parameter int NUM_THREADS  = 1024,
  parameter int NUM_BARRIERS = 16,
  parameter int CNT_W        = 11,
  localparam int TID_W       = $clog2(NUM_THREADS),
  localparam int BAR_W       = $clog2(NUM_BARRIERS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_valid,
  output logic                               cmd_ready,
  input  logic                               cmd_op,
  input  logic [BAR_W-1:0]                   cmd_bar,
  input  logic [TID_W-1:0]                   cmd_tid,
  input  logic [CNT_W-1:0]                   cmd_cnt,
  input  logic [NUM_BARRIERS-1:0][CNT_W-1:0] arr_cnt,
  input  logic                               qa_blocked,
  input  logic                               qb_blocked,
  input  logic [BAR_W-1:0]                   qb_bar,
  input  logic [CNT_W-1:0]                   qb_req,
  output logic [TID_W-1:0]                   qb_tid,
  output logic                               arr_en,
  output logic                               done_en,
  output logic [BAR_W-1:0]                   done_bar,
  output logic                               set_en,
  output logic                               clr_en,
  output logic                               rel_valid,
  output logic [TID_W-1:0]                   rel_tid,
  output logic                               err_valid,
  output logic [TID_W-1:0]                   err_tid
);
  localparam logic [TID_W-1:0] LAST_SLOT = TID_W'(NUM_THREADS - 1);

  nb_state_e        state_q, state_nxt;
  logic [TID_W-1:0] ptr_q, ptr_nxt;
  logic [BAR_W-1:0] sbar_q, sbar_nxt;
  logic             ctl_en;
  logic             accept, hit;
  logic             rel_nxt, err_nxt;
  logic [TID_W-1:0] rel_tid_nxt, err_tid_nxt;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign qb_tid    = ptr_q;
  assign hit       = qb_blocked && (qb_bar == sbar_q) && (qb_req <= arr_cnt[sbar_q]);

  always_comb begin
    state_nxt   = state_q;
    ptr_nxt     = ptr_q;
    sbar_nxt    = sbar_q;
    ctl_en      = 1'b0;
    arr_en      = 1'b0;
    done_en     = 1'b0;
    done_bar    = cmd_bar;
    set_en      = 1'b0;
    clr_en      = 1'b0;
    rel_nxt     = 1'b0;
    rel_tid_nxt = cmd_tid;
    err_nxt     = 1'b0;
    err_tid_nxt = cmd_tid;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (nb_op_e'(cmd_op) == OP_ARRIVE) begin
            arr_en    = 1'b1;
            ctl_en    = 1'b1;
            state_nxt = ST_SCAN;
            ptr_nxt   = '0;
            sbar_nxt  = cmd_bar;
          end else if (qa_blocked) begin
            err_nxt = 1'b1;
          end else if (arr_cnt[cmd_bar] >= cmd_cnt) begin
            done_en = 1'b1;
            rel_nxt = 1'b1;
          end else begin
            set_en = 1'b1;
          end
        end
      end
      ST_SCAN: begin
        ctl_en   = 1'b1;
        done_bar = sbar_q;
        if (hit) begin
          clr_en      = 1'b1;
          done_en     = 1'b1;
          rel_nxt     = 1'b1;
          rel_tid_nxt = ptr_q;
        end
        ptr_nxt = ptr_q + 1'b1;
        if (ptr_q == LAST_SLOT) state_nxt = ST_IDLE;
      end
      default: begin
        ctl_en    = 1'b1;
        state_nxt = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      sbar_q  <= '0;
    end else if (ctl_en) begin
      state_q <= state_nxt;
      ptr_q   <= ptr_nxt;
      sbar_q  <= sbar_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_valid <= 1'b0;
      rel_tid   <= '0;
      err_valid <= 1'b0;
      err_tid   <= '0;
    end else begin
      rel_valid <= rel_nxt;
      err_valid <= err_nxt;
      if (rel_nxt) rel_tid <= rel_tid_nxt;
      if (err_nxt) err_tid <= err_tid_nxt;
    end
  end
endmodule

// File: rtl/nb_barrier_unit.sv
module nb_barrier_unit #(
  parameter int NUM_BARRIERS = 16,
  parameter int NUM_THREADS  = 1024,
  parameter int CNT_W        = 11,
  localparam int BAR_W       = $clog2(NUM_BARRIERS),
  localparam int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_op,
  input  logic [BAR_W-1:0] cmd_bar,
  input  logic [TID_W-1:0] cmd_tid,
  input  logic [CNT_W-1:0] cmd_cnt,
  output logic             rel_valid,
  output logic [TID_W-1:0] rel_tid,
  output logic             err_valid,
  output logic [TID_W-1:0] err_tid
);
  logic                               rst_sync_n;
  logic [NUM_BARRIERS-1:0][CNT_W-1:0] arr_cnt;
  logic [NUM_BARRIERS-1:0][CNT_W:0]   part_cnt;
  logic                               arr_en, done_en, set_en, clr_en;
  logic [BAR_W-1:0]                   done_bar;
  logic                               tid_blocked;
  logic                               qb_blocked;
  logic [BAR_W-1:0]                   qb_bar;
  logic [CNT_W-1:0]                   qb_req;
  logic [TID_W-1:0]                   qb_tid;

  nb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nb_counter_bank #(
    .NUM_BARRIERS (NUM_BARRIERS),
    .CNT_W        (CNT_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .arr_en     (arr_en),
    .arr_bar    (cmd_bar),
    .arr_cnt_in (cmd_cnt),
    .done_en    (done_en),
    .done_bar   (done_bar),
    .arr_cnt    (arr_cnt),
    .part_cnt   (part_cnt)
  );

  nb_wait_table #(
    .NUM_THREADS  (NUM_THREADS),
    .NUM_BARRIERS (NUM_BARRIERS),
    .CNT_W        (CNT_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .set_en     (set_en),
    .set_tid    (cmd_tid),
    .set_bar    (cmd_bar),
    .set_req    (cmd_cnt),
    .clr_en     (clr_en),
    .clr_tid    (qb_tid),
    .qa_tid     (cmd_tid),
    .qa_blocked (tid_blocked),
    .qb_tid     (qb_tid),
    .qb_blocked (qb_blocked),
    .qb_bar     (qb_bar),
    .qb_req     (qb_req)
  );

  nb_ctrl #(
    .NUM_THREADS  (NUM_THREADS),
    .NUM_BARRIERS (NUM_BARRIERS),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_bar    (cmd_bar),
    .cmd_tid    (cmd_tid),
    .cmd_cnt    (cmd_cnt),
    .arr_cnt    (arr_cnt),
    .qa_blocked (tid_blocked),
    .qb_blocked (qb_blocked),
    .qb_bar     (qb_bar),
    .qb_req     (qb_req),
    .qb_tid     (qb_tid),
    .arr_en     (arr_en),
    .done_en    (done_en),
    .done_bar   (done_bar),
    .set_en     (set_en),
    .clr_en     (clr_en),
    .rel_valid  (rel_valid),
    .rel_tid    (rel_tid),
    .err_valid  (err_valid),
    .err_tid    (err_tid)
  );
endmodule

// File: rtl/nb_barrier_unit_chk.sv
module nb_barrier_unit_chk #(
  parameter int NUM_BARRIERS = 16,
  parameter int NUM_THREADS  = 1024,
  parameter int CNT_W        = 11,
  localparam int BAR_W       = $clog2(NUM_BARRIERS),
  localparam int TID_W       = $clog2(NUM_THREADS)
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               cmd_valid,
  input logic                               cmd_ready,
  input logic                               cmd_op,
  input logic [BAR_W-1:0]                   cmd_bar,
  input logic                               tid_blocked,
  input logic                               rel_valid,
  input logic                               err_valid,
  input logic [NUM_BARRIERS-1:0][CNT_W-1:0] arr_cnt
);
  logic             acc_arr_q, acc_sync_q;
  logic [BAR_W-1:0] bar_q;
  logic [CNT_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_arr_q  <= 1'b0;
      acc_sync_q <= 1'b0;
      bar_q      <= '0;
      prev_q     <= '0;
    end else begin
      acc_arr_q  <= cmd_valid && cmd_ready && !cmd_op;
      acc_sync_q <= cmd_valid && cmd_ready && cmd_op;
      bar_q      <= cmd_bar;
      prev_q     <= arr_cnt[cmd_bar];
    end
  end

  p_arrive_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_arr_q && (prev_q != {CNT_W{1'b1}})) |-> (arr_cnt[bar_q] == prev_q + 1'b1));

  p_sync_never_adds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sync_q |-> (arr_cnt[bar_q] <= prev_q));

  p_walk_holds_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_op) |=> !cmd_ready);

  p_parked_sync_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op && tid_blocked) |=> (err_valid && !rel_valid));

  p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rel_valid, err_valid}));
endmodule

bind nb_barrier_unit nb_barrier_unit_chk #(
  .NUM_BARRIERS (NUM_BARRIERS),
  .NUM_THREADS  (NUM_THREADS),
  .CNT_W        (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_op      (cmd_op),
  .cmd_bar     (cmd_bar),
  .tid_blocked (tid_blocked),
  .rel_valid   (rel_valid),
  .err_valid   (err_valid),
  .arr_cnt     (arr_cnt)
);

// File: tb/nb_barrier_unit_test.sv
`timescale 1ns/1ps
module nb_barrier_unit_test;
  localparam int NB    = 4;
  localparam int NT    = 8;
  localparam int CW    = 4;
  localparam int BAR_W = $clog2(NB);
  localparam int TID_W = $clog2(NT);
  localparam int ARR_SAT  = (1 << CW) - 1;
  localparam int PART_SAT = -(1 << CW);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_valid, cmd_ready, cmd_op;
  logic [BAR_W-1:0] cmd_bar;
  logic [TID_W-1:0] cmd_tid;
  logic [CW-1:0]    cmd_cnt;
  logic             rel_valid, err_valid;
  logic [TID_W-1:0] rel_tid, err_tid;

  always #10 clk = ~clk;

  nb_barrier_unit #(.NUM_BARRIERS(NB), .NUM_THREADS(NT), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bar(cmd_bar), .cmd_tid(cmd_tid), .cmd_cnt(cmd_cnt),
    .rel_valid(rel_valid), .rel_tid(rel_tid), .err_valid(err_valid), .err_tid(err_tid)
  );

  int n_chk = 0;
  int n_err = 0;
  int m_arr [NB];
  int m_part [NB];
  bit m_blk [NT];
  int m_wb [NT];
  int m_wr [NT];
  bit g_rel, g_err;
  int g_nrel;

  task automatic chk_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void m_reset();
    for (int b = 0; b < NB; b++) begin m_arr[b] = 0; m_part[b] = 0; end
    for (int t = 0; t < NT; t++) begin m_blk[t] = 0; m_wb[t] = 0; m_wr[t] = 0; end
  endfunction

  function automatic void m_complete(int b);
    if (m_part[b] == 1) m_arr[b] = 0;
    if (m_part[b] > PART_SAT) m_part[b] = m_part[b] - 1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_reset();
    chk_eq("R1", "ready after reset", int'(cmd_ready), 1);
    chk_eq("R1", "rel_valid after reset", int'(rel_valid), 0);
    chk_eq("R1", "err_valid after reset", int'(err_valid), 0);
  endtask

  task automatic issue(bit op, int b, int t, int c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_bar   = BAR_W'(b);
    cmd_tid   = TID_W'(t);
    cmd_cnt   = CW'(c);
    chk_eq("R8", "ready while idle", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    g_rel = 0; g_err = 0; g_nrel = 0;
    if (!op) begin
      if (m_arr[b] < ARR_SAT) m_arr[b] = m_arr[b] + 1;
      if (c > m_part[b]) m_part[b] = c;
      chk_eq("R2", "no release on arrive accept", int'(rel_valid), 0);
      chk_eq("R8", "ready low after arrive", int'(cmd_ready), 0);
      for (int k = 0; k < NT; k++) begin
        bit hit;
        @(negedge clk);
        hit = m_blk[k] && (m_wb[k] == b) && (m_wr[k] <= m_arr[b]);
        if (hit) begin
          m_blk[k] = 0;
          m_complete(b);
          g_nrel++;
        end
        chk_eq("R5", $sformatf("walk slot %0d release", k), int'(rel_valid), int'(hit));
        if (hit) chk_eq("R5", "walk release id", int'(rel_tid), k);
        chk_eq("R8", "ready during walk", int'(cmd_ready), (k == NT - 1) ? 1 : 0);
      end
    end else begin
      if (m_blk[t]) begin
        g_err = 1;
      end else if (m_arr[b] >= c) begin
        g_rel = 1;
        m_complete(b);
      end else begin
        m_blk[t] = 1; m_wb[t] = b; m_wr[t] = c;
      end
      chk_eq("R9", "err_valid", int'(err_valid), int'(g_err));
      if (g_err) chk_eq("R9", "err_tid", int'(err_tid), t);
      chk_eq("R3", "rel_valid", int'(rel_valid), int'(g_rel));
      if (g_rel) chk_eq("R3", "rel_tid", int'(rel_tid), t);
      chk_eq("R8", "ready after sync", int'(cmd_ready), 1);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    cmd_valid = 1'b0; cmd_op = 1'b0; cmd_bar = '0; cmd_tid = '0; cmd_cnt = '0;
    rst_n = 1'b0;
    do_reset();

    // R1: fresh barrier has no arrivals
    issue(1, 0, 0, 1);
    chk_eq("R1", "sync on fresh barrier released", int'(g_rel), 0);
    // R4: a sync does not count as an arrival
    issue(1, 0, 1, 1);
    chk_eq("R4", "second sync released", int'(g_rel), 0);
    // R10: arrive on barrier 1 leaves barrier 0 waiters parked
    issue(0, 1, 7, 1);
    chk_eq("R10", "releases on other barrier", g_nrel, 0);
    // R5: only waiters whose need is met are freed
    issue(1, 0, 2, 2);
    issue(0, 0, 7, 3);
    chk_eq("R5", "releases after first arrive", g_nrel, 2);
    issue(0, 0, 7, 1);
    chk_eq("R5", "releases after second arrive", g_nrel, 1);
    // R6: participant count drained, arrivals cleared
    issue(1, 0, 3, 1);
    chk_eq("R6", "sync after barrier reset released", int'(g_rel), 0);
    issue(0, 0, 7, 1);
    chk_eq("R6", "waiter freed by new arrive", g_nrel, 1);
    // R9: sync from a parked slot is dropped and flagged
    issue(1, 2, 4, 1);
    issue(1, 2, 4, 0);
    chk_eq("R9", "error raised", int'(g_err), 1);
    chk_eq("R9", "dropped sync released", int'(g_rel), 0);
    issue(0, 2, 7, 1);
    chk_eq("R9", "parked entry kept", g_nrel, 1);
    // R7: participant count below zero keeps arrivals
    issue(1, 3, 5, 0);
    chk_eq("R7", "zero-need sync completes", int'(g_rel), 1);
    issue(0, 3, 7, 0);
    issue(1, 3, 5, 1);
    chk_eq("R7", "first sync after arrive", int'(g_rel), 1);
    issue(1, 3, 6, 1);
    chk_eq("R7", "arrivals kept at negative count", int'(g_rel), 1);

    // R11: saturation of both counters
    do_reset();
    for (int i = 0; i < 17; i++) issue(0, 0, 7, 0);
    issue(1, 0, 0, ARR_SAT);
    chk_eq("R11", "arrival count held at max", int'(g_rel), 1);
    for (int i = 0; i < 17; i++) issue(1, 1, 1, 0);
    issue(0, 1, 7, 1);
    issue(1, 1, 1, 1);
    chk_eq("R11", "sync after floor", int'(g_rel), 1);
    issue(1, 1, 2, 1);
    chk_eq("R11", "barrier cleared after floor", int'(g_rel), 0);

    // Random traffic against the bench model
    do_reset();
    for (int i = 0; i < 500; i++) begin
      issue(1'($urandom_range(0, 1)), int'($urandom_range(0, NB - 1)),
            int'($urandom_range(0, NT - 1)), int'($urandom_range(0, 3)));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule